// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Packed-Decimal Arithmetic

This block is the arithmetic and logic unit of an 8-bit accumulator machine. Each cycle it takes an accumulator byte, an operand byte, the incoming status byte and a 4-bit operation code. It computes the new result byte and the new status byte and registers both, so they appear one clock later. The supported operations are add with carry, subtract with borrow (binary or packed decimal, chosen by the decimal bit of the incoming status), compare, AND, OR, XOR, bit test, shift left, shift right and the two rotates through carry. Codes with no operation assigned pass the accumulator and status through unchanged.

Decimal results are produced by running the binary sum once and then adding a single correction term built from the half-carries. Zero and negative therefore always describe the binary sum, even in decimal mode. The status byte layout is carry at bit 0, zero at bit 1, interrupt mask at bit 2, decimal at bit 3, break at bit 4, spare at bit 5, overflow at bit 6 and negative at bit 7.

The block has no state machine. Its only state is the output register, which is either reset (both outputs zero) or holding the previous cycle's result. It moves from reset to holding when reset is released, and it stays in holding on every following edge.

Top module: `acc_alu`

## Requirements
- R1: While rst_n is low, res_out and stat_out are 0x00, and both are forced to 0x00 as soon as rst_n falls, without waiting for a clock edge.
- R2: res_out and stat_out show the result of the inputs sampled at the previous rising clock edge. A change of the inputs between edges leaves them unchanged.
- R3: For add (op 0x0) and subtract (op 0x1), the unit adds the accumulator, the operand (inverted for subtract) and status bit 0 as carry-in. Bit 0 becomes the carry out of bit 7. Bit 6 (overflow) is set when (sum XOR acc) AND (sum XOR effective operand) has bit 7 set.
- R4: For add and subtract, bit 1 (zero) and bit 7 (negative) come from the low byte of the binary sum, taken before any decimal correction.
- R5: With status bit 3 set, add (op 0x0) adds three times ((((sum + 0x66) XOR acc XOR operand) >> 3) AND 0x22) to the sum. The result is the low byte of that total, and carry is set if any bit above bit 7 is set.
- R6: With status bit 3 set, subtract (op 0x1) first takes 0x66 away from the inverted operand in 16-bit arithmetic. It then applies the add path and the correction of R5 to that value.
- R7: Compare (op 0x2) sets zero and negative from the low byte of acc minus operand and sets carry exactly when acc >= operand (unsigned). The result byte is the accumulator, and overflow is kept.
- R8: AND (op 0x3), OR (op 0x4) and XOR (op 0x5) put the logic result on res_out and set zero and negative from it. Carry and overflow are kept.
- R9: Bit test (op 0x6) sets zero when acc AND operand is 0x00, copies operand bit 7 into negative and bit 6 into overflow, keeps carry and returns the accumulator.
- R10: Shift left (op 0x7) and rotate left (op 0x9) move acc bit 7 into carry. Shift right (op 0x8) and rotate right (op 0xA) move acc bit 0 into carry. The rotates fill the vacated bit with the old carry and the shifts fill it with 0. All four set zero and negative from the result, and the operand is ignored.
- R11: Codes 0xB to 0xF return the accumulator and status unchanged. Status bits 2, 3, 4 and 5 are copied from stat_in under every code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_in | input | 8 | Accumulator byte |
| opnd_in | input | 8 | Operand byte |
| stat_in | input | 8 | Incoming status byte |
| op_sel | input | 4 | Operation code |
| res_out | output | 8 | Registered result byte |
| stat_out | output | 8 | Registered status byte |

## Verification
Two things can happen in the same cycle: the output register taking a new operation, and reset. The register also presents one result while the next operation is already on the inputs. To provoke the first case, the bench holds a pass-through operation with non-zero data, lowers reset between edges, and expects both outputs to read zero at once and across the next edge. After release it expects the held operation to appear after exactly one edge. To provoke the second case, the bench drives a new add just after a falling edge and expects the outputs to still show the previous vector before the rising edge and the new sum after it.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
    localparam int DW = 8;
    localparam int XW = 2 * DW;

    localparam int ST_C = 0;
    localparam int ST_Z = 1;
    localparam int ST_D = 3;
    localparam int ST_V = 6;
    localparam int ST_N = 7;

    typedef enum logic [3:0] {
        OP_ADD = 4'h0,
        OP_SUB = 4'h1,
        OP_CMP = 4'h2,
        OP_AND = 4'h3,
        OP_OR  = 4'h4,
        OP_XOR = 4'h5,
        OP_BIT = 4'h6,
        OP_SHL = 4'h7,
        OP_SHR = 4'h8,
        OP_ROL = 4'h9,
        OP_ROR = 4'hA
    } alu_op_e;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
    import acc_alu_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] m,
    input  logic          cin,
    input  logic          dec,
    input  logic          sub,
    output logic [DW-1:0] res,
    output logic          cout,
    output logic          zf,
    output logic          nf,
    output logic          vf
);
    localparam logic [XW-1:0] BIAS = XW'(16'h0066);
    localparam logic [XW-1:0] HMSK = XW'(16'h0022);

    logic [XW-1:0] eff_m;
    logic [XW-1:0] bin_sum;
    logic [XW-1:0] hc_term;
    logic [XW-1:0] fix;
    logic [XW-1:0] total;
    logic [DW-1:0] ov_vec;

    always_comb begin
        // effective operand, widened; decimal subtract pre-biases it
        eff_m = {{(XW-DW){1'b0}}, (sub ? ~m : m)};
        if (dec && sub) begin
            eff_m = eff_m - BIAS;
        end
        bin_sum = {{(XW-DW){1'b0}}, a} + eff_m + {{(XW-1){1'b0}}, cin};
        zf      = (bin_sum[DW-1:0] == '0);
        nf      = bin_sum[DW-1];
        ov_vec  = (bin_sum[DW-1:0] ^ a) & (bin_sum[DW-1:0] ^ eff_m[DW-1:0]);
        vf      = ov_vec[DW-1];
        // half-carry correction: 0x00, 0x06, 0x60 or 0x66
        hc_term = (((bin_sum + BIAS) ^ {{(XW-DW){1'b0}}, a} ^ eff_m) >> 3) & HMSK;
        fix     = (hc_term << 1) + hc_term;
        total   = dec ? (bin_sum + fix) : bin_sum;
        res     = total[DW-1:0];
        cout    = |total[XW-1:DW];
    end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
(
    input  logic [3:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] m,
    output logic [DW-1:0] lres,
    output logic [DW-1:0] diff,
    output logic          ge
);
    logic [DW:0] wide_diff;

    always_comb begin
        wide_diff = {1'b0, a} - {1'b0, m};
        diff      = wide_diff[DW-1:0];
        ge        = ~wide_diff[DW];
        case (op)
            OP_OR:   lres = a | m;
            OP_XOR:  lres = a ^ m;
            default: lres = a & m;
        endcase
    end
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
    import acc_alu_pkg::*;
(
    input  logic [3:0]    op,
    input  logic [DW-1:0] a,
    input  logic          cin,
    output logic [DW-1:0] sres,
    output logic          cout
);
    always_comb begin
        case (op)
            OP_SHL: begin
                sres = {a[DW-2:0], 1'b0};
                cout = a[DW-1];
            end
            OP_SHR: begin
                sres = {1'b0, a[DW-1:1]};
                cout = a[0];
            end
            OP_ROL: begin
                sres = {a[DW-2:0], cin};
                cout = a[DW-1];
            end
            OP_ROR: begin
                sres = {cin, a[DW-1:1]};
                cout = a[0];
            end
            default: begin
                sres = a;
                cout = cin;
            end
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] opnd_in,
    input  logic [DW-1:0] stat_in,
    input  logic [3:0]    op_sel,
    output logic [DW-1:0] res_out,
    output logic [DW-1:0] stat_out
);
    logic [DW-1:0] as_res;
    logic          as_c, as_z, as_n, as_v;
    logic [DW-1:0] lg_res, lg_diff;
    logic          lg_ge;
    logic [DW-1:0] sh_res;
    logic          sh_c;
    logic [DW-1:0] nxt_res, nxt_st;

    acc_alu_addsub u_addsub (
        .a    (acc_in),
        .m    (opnd_in),
        .cin  (stat_in[ST_C]),
        .dec  (stat_in[ST_D]),
        .sub  (op_sel == OP_SUB),
        .res  (as_res),
        .cout (as_c),
        .zf   (as_z),
        .nf   (as_n),
        .vf   (as_v)
    );

    acc_alu_logic u_logic (
        .op   (op_sel),
        .a    (acc_in),
        .m    (opnd_in),
        .lres (lg_res),
        .diff (lg_diff),
        .ge   (lg_ge)
    );

    acc_alu_shift u_shift (
        .op   (op_sel),
        .a    (acc_in),
        .cin  (stat_in[ST_C]),
        .sres (sh_res),
        .cout (sh_c)
    );

    always_comb begin
        nxt_res = acc_in;
        nxt_st  = stat_in;
        unique case (op_sel)
            OP_ADD, OP_SUB: begin
                nxt_res      = as_res;
                nxt_st[ST_C] = as_c;
                nxt_st[ST_Z] = as_z;
                nxt_st[ST_V] = as_v;
                nxt_st[ST_N] = as_n;
            end
            OP_CMP: begin
                nxt_st[ST_C] = lg_ge;
                nxt_st[ST_Z] = (lg_diff == '0);
                nxt_st[ST_N] = lg_diff[DW-1];
            end
            OP_AND, OP_OR, OP_XOR: begin
                nxt_res      = lg_res;
                nxt_st[ST_Z] = (lg_res == '0);
                nxt_st[ST_N] = lg_res[DW-1];
            end
            OP_BIT: begin
                nxt_st[ST_Z] = (lg_res == '0);
                nxt_st[ST_V] = opnd_in[DW-2];
                nxt_st[ST_N] = opnd_in[DW-1];
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                nxt_res      = sh_res;
                nxt_st[ST_C] = sh_c;
                nxt_st[ST_Z] = (sh_res == '0);
                nxt_st[ST_N] = sh_res[DW-1];
            end
            default: begin
                nxt_res = acc_in;
                nxt_st  = stat_in;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_out  <= '0;
            stat_out <= '0;
        end else begin
            res_out  <= nxt_res;
            stat_out <= nxt_st;
        end
    end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import acc_alu_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] acc_in,
    input logic [DW-1:0] opnd_in,
    input logic [DW-1:0] stat_in,
    input logic [3:0]    op_sel,
    input logic [DW-1:0] res_out,
    input logic [DW-1:0] stat_out
);
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_zero: assert (res_out == '0 && stat_out == '0)
                else $error("R1 outputs not cleared in reset");
        end
    end

    a_r11_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > OP_ROR) |=> (res_out == $past(acc_in) && stat_out == $past(stat_in)))
        else $error("R11 unused code altered data");

    a_r11_ctrl_bits: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stat_out[5:2] == $past(stat_in[5:2])))
        else $error("R11 control bits altered");

    a_r7_cmp_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_CMP) |=> (stat_out[ST_C] == ($past(acc_in) >= $past(opnd_in))
                                && res_out == $past(acc_in)))
        else $error("R7 compare carry or result wrong");

    a_r9_bit_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_BIT) |=> (stat_out[7:6] == $past(opnd_in[7:6])
                                && res_out == $past(acc_in)))
        else $error("R9 bit test copy wrong");

    a_r8_logic_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR)
        |=> (stat_out[ST_C] == $past(stat_in[ST_C]) && stat_out[ST_V] == $past(stat_in[ST_V])))
        else $error("R8 logic op touched carry or overflow");

    a_r10_left_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_SHL || op_sel == OP_ROL) |=> (stat_out[ST_C] == $past(acc_in[DW-1])))
        else $error("R10 left shift carry wrong");

    a_r10_right_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_SHR || op_sel == OP_ROR) |=> (stat_out[ST_C] == $past(acc_in[0])))
        else $error("R10 right shift carry wrong");
endmodule

bind acc_alu acc_alu_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_in   (acc_in),
    .opnd_in  (opnd_in),
    .stat_in  (stat_in),
    .op_sel   (op_sel),
    .res_out  (res_out),
    .stat_out (stat_out)
);

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] acc_in = 8'h00;
    logic [7:0] opnd_in = 8'h00;
    logic [7:0] stat_in = 8'h00;
    logic [3:0] op_sel = 4'h0;
    logic [7:0] res_out;
    logic [7:0] stat_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    acc_alu u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_in   (acc_in),
        .opnd_in  (opnd_in),
        .stat_in  (stat_in),
        .op_sel   (op_sel),
        .res_out  (res_out),
        .stat_out (stat_out)
    );

    // {op, acc, operand, status in, expected result, expected status}
    localparam int NV = 24;
    localparam logic [43:0] VEC [0:NV-1] = '{
        44'h0_7F_01_20_80_E0, 44'h0_FF_01_20_00_23, 44'h0_10_20_35_31_34,
        44'h0_45_38_28_83_28, 44'h0_99_01_28_00_A9, 44'h1_50_30_21_20_21,
        44'h1_00_01_21_FF_A0, 44'h1_80_01_21_7F_61, 44'h1_00_01_29_99_A8,
        44'h1_50_00_29_50_A9, 44'h2_40_40_E0_40_63, 44'h2_10_20_21_10_A0,
        44'h3_F0_0F_61_00_63, 44'h4_80_01_22_81_A0, 44'h5_FF_0F_20_F0_A0,
        44'h6_01_C0_20_01_E2, 44'h6_FF_01_E1_FF_21, 44'h7_81_FF_20_02_21,
        44'h8_01_FF_A0_00_23, 44'h9_40_FF_21_81_A0, 44'hA_01_FF_21_80_A1,
        44'hA_02_FF_20_01_20, 44'hB_5A_33_C3_5A_C3, 44'hF_00_FF_00_00_00
    };
    localparam string TAG [0:NV-1] = '{
        "R3", "R3", "R11", "R5", "R4", "R3", "R3", "R3", "R6", "R6", "R7", "R7",
        "R8", "R8", "R8", "R9", "R9", "R10", "R10", "R10", "R10", "R10", "R11", "R11"
    };

    task automatic chk8(input string tag, input string what,
                        input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset holds outputs low even with live inputs
        op_sel = 4'h0; acc_in = 8'h12; opnd_in = 8'h01; stat_in = 8'h20;
        repeat (3) @(negedge clk);
        chk8("R1", "res in reset", res_out, 8'h00);
        chk8("R1", "stat in reset", stat_out, 8'h00);
        rst_n = 1'b1;

        // table walk: drive on falling edge, check one edge later
        for (int i = 0; i < NV; i++) begin
            op_sel  = VEC[i][43:40];
            acc_in  = VEC[i][39:32];
            opnd_in = VEC[i][31:24];
            stat_in = VEC[i][23:16];
            @(negedge clk);
            chk8(TAG[i], $sformatf("vec %0d res", i), res_out, VEC[i][15:8]);
            chk8(TAG[i], $sformatf("vec %0d stat", i), stat_out, VEC[i][7:0]);
        end

        // R2: a new input does not show before the rising edge
        op_sel = 4'h0; acc_in = 8'h01; opnd_in = 8'h01; stat_in = 8'h20;
        #1;
        chk8("R2", "res before edge", res_out, 8'h00);
        chk8("R2", "stat before edge", stat_out, 8'h00);
        @(negedge clk);
        chk8("R2", "res after edge", res_out, 8'h02);
        chk8("R2", "stat after edge", stat_out, 8'h20);

        // R1: reset arriving while an operation is held
        op_sel = 4'hC; acc_in = 8'h77; opnd_in = 8'h00; stat_in = 8'hFF;
        @(negedge clk);
        chk8("R11", "pass res", res_out, 8'h77);
        chk8("R11", "pass stat", stat_out, 8'hFF);
        rst_n = 1'b0;
        #1;
        chk8("R1", "async clear res", res_out, 8'h00);
        chk8("R1", "async clear stat", stat_out, 8'h00);
        @(negedge clk);
        chk8("R1", "held clear stat", stat_out, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk8("R2", "res after release", res_out, 8'h77);
        chk8("R2", "stat after release", stat_out, 8'hFF);

        finish_run();
    end
endmodule